// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Dual DAC Word Loader

This block sits between an 8-bit host data bus and a two-channel 12-bit digital-to-analog converter. Each channel keeps a staging word, built from an 8-bit low part and a 4-bit high part. The host writes each part separately, using a chip select, a write strobe and two address lines.

A separate transfer strobe copies both staging words into the output words at the same clock edge. Only the output words drive the converter codes. A new value therefore reaches the converter only as a complete word, and both channels change together. It is never visible half-written.

All strobes are active low and act on their rising edge. The block samples them in the system clock domain.

Top module: `dac_byte_loader`

## Requirements
- R1: After reset, both output words read 0.
- R2: A write with address code 00 stores bus bits 7:0 into staging bits 7:0 of channel A. Address code 01 stores bus bits 3:0 into staging bits 11:8 of channel A, and bus bits 7:4 are ignored.
- R3: Address codes 10 and 11 act on channel B in the same way as codes 00 and 01 act on channel A.
- R4: Writing one part of a staging word leaves the other part, and the other channel, unchanged.
- R5: A write takes effect only when chip select is low in the clock cycle in which the write strobe's rising edge is seen. Otherwise it changes nothing.
- R6: Writes to staging words never change the output words.
- R7: A rising edge of the transfer strobe copies both staging words into both output words at the same clock edge.
- R8: The output words hold their value until the next transfer edge. A transfer with no intervening writes leaves them unchanged.
- R9: When a write edge and a transfer edge are seen in the same cycle, the transfer copies the staging contents as they stood before that write.
- R10: Holding a strobe low has no effect. Only its low-to-high transition acts, and it uses the bus and address values present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, acts on rising edge |
| addr_i | input | 2 | Target select: bit 1 picks the channel, bit 0 picks the high part |
| data_i | input | 8 | Host data bus |
| xfer_ni | input | 1 | Transfer strobe, acts on rising edge |
| dac_a_o | output | 12 | Channel A output word |
| dac_b_o | output | 12 | Channel B output word |

## Verification
The staging words are not visible at the ports. Every effect of a write, whether it should happen or not, is therefore checked by following the write with a transfer and comparing both output words against the model. The hardest situation to reach is a write edge and a transfer edge landing in the same clock cycle. The stimulus releases both strobes at the same instant, both in a directed case and at random, so the order of copy and write is exercised. A long low hold of the write strobe with a transfer in the middle covers the edge-only behaviour.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned WORD_W = 12;
  localparam int unsigned HI_W   = WORD_W - BUS_W;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned ADDR_W = $clog2(NUM_CH) + 1;
  typedef logic [WORD_W-1:0] dac_word_t;
endpackage

// File: rtl/dac_strobe_edge.sv
module dac_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= strobe_ni;
  end

  assign rise_o = !prev_q && strobe_ni;

  // R10: a rise is a single-cycle event, never a level
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dac_stage_word.sv
module dac_stage_word
  import dac_loader_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] data_i,
  output dac_word_t        word_o
);
  logic [BUS_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else if (wr_lo_i) lo_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else if (wr_hi_i) hi_q <= data_i[HI_W-1:0];
  end

  assign word_o = {hi_q, lo_q};

  a_r4_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> $stable(hi_q));
  a_r4_lo_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> $stable(lo_q));
endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
  import dac_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  data_i,
  input  logic              xfer_ni,
  output logic [WORD_W-1:0] dac_a_o,
  output logic [WORD_W-1:0] dac_b_o
);
  logic      wr_rise, xfer_rise, wr_go;
  dac_word_t stage_w [NUM_CH];
  dac_word_t out_q   [NUM_CH];

  dac_strobe_edge u_wr_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_ni(wr_ni), .rise_o(wr_rise));
  dac_strobe_edge u_xfer_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_ni(xfer_ni), .rise_o(xfer_rise));

  assign wr_go = wr_rise && !cs_ni;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_go && (addr_i[ADDR_W-1:1] == c[ADDR_W-2:0]);

    dac_stage_word u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_lo_i(hit && !addr_i[0]),
      .wr_hi_i(hit && addr_i[0]),
      .data_i (data_i),
      .word_o (stage_w[c])
    );

    // copy sees pre-write staging value when both edges coincide
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        out_q[c] <= '0;
      else if (xfer_rise) out_q[c] <= stage_w[c];
    end

    a_r6_r8_out_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !xfer_rise |=> $stable(out_q[c]));
    a_r7_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_rise |=> out_q[c] == $past(stage_w[c]));
    a_r5_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_rise && cs_ni) |=> $stable(stage_w[c]));
  end

  assign dac_a_o = out_q[0];
  assign dac_b_o = out_q[1];
endmodule

// File: tb/tb_dac_byte_loader.sv
`timescale 1ns/1ps
module tb_dac_byte_loader;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, wr_ni = 1'b1, xfer_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [11:0] dac_a_o, dac_b_o;

  int total = 0, bad = 0;
  logic [11:0] m_in [2];
  logic [11:0] m_out [2];

  always #2.5 clk_i = ~clk_i;

  dac_byte_loader dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni),
    .addr_i(addr_i), .data_i(data_i), .xfer_ni(xfer_ni),
    .dac_a_o(dac_a_o), .dac_b_o(dac_b_o));

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string tag, logic [11:0] got, logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %03h expected %03h", tag, got, exp);
    end
  endtask

  task automatic chk_both(string tag);
    chk({tag, " chA"}, dac_a_o, m_out[0]);
    chk({tag, " chB"}, dac_b_o, m_out[1]);
  endtask

  function automatic logic [11:0] model_write(logic [11:0] w, logic hi, logic [7:0] d);
    return hi ? {d[3:0], w[7:0]} : {w[11:8], d};
  endfunction

  // one bus operation: strobes low for a cycle, released together
  task automatic op(logic wr, logic xf, logic cs, logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_ni = !wr; xfer_ni = !xf; cs_ni = cs; addr_i = a; data_i = d;
    @(negedge clk_i);
    wr_ni = 1'b1; xfer_ni = 1'b1;
    @(negedge clk_i);
    if (xf) begin m_out[0] = m_in[0]; m_out[1] = m_in[1]; end
    if (wr && !cs) m_in[a[1]] = model_write(m_in[a[1]], a[0], d);
  endtask

  initial begin
    m_in[0] = '0; m_in[1] = '0; m_out[0] = '0; m_out[1] = '0;
    repeat (3) @(negedge clk_i);
    chk_both("R1 reset");
    rst_ni = 1'b1;

    op(1, 0, 0, 2'b00, 8'hA5);
    chk_both("R6 no change before transfer");
    op(1, 0, 0, 2'b01, 8'hF3);
    op(0, 1, 0, 2'b00, 8'h00);
    chk("R2 A word", dac_a_o, 12'h3A5);
    chk("R4 B untouched", dac_b_o, 12'h000);

    op(1, 0, 0, 2'b10, 8'h5C);
    op(1, 0, 0, 2'b11, 8'hE9);
    op(0, 1, 0, 2'b00, 8'h00);
    chk("R3 B word", dac_b_o, 12'h95C);
    chk("R4 A kept", dac_a_o, 12'h3A5);

    op(1, 0, 0, 2'b00, 8'h11);
    op(0, 1, 0, 2'b00, 8'h00);
    chk("R4 hi kept on low write", dac_a_o, 12'h311);

    op(1, 0, 1, 2'b01, 8'h0F);
    op(0, 1, 0, 2'b00, 8'h00);
    chk_both("R5 cs high ignored");

    op(0, 1, 0, 2'b00, 8'h00);
    chk_both("R8 repeat transfer holds");

    op(1, 0, 0, 2'b01, 8'h07);
    op(1, 1, 0, 2'b00, 8'h22);
    chk("R9 same-edge copy old", dac_a_o, 12'h711);
    op(0, 1, 0, 2'b00, 8'h00);
    chk("R9 write then lands", dac_a_o, 12'h722);

    // R10: hold write low, transfer meanwhile, release with new data
    @(negedge clk_i);
    wr_ni = 1'b0; cs_ni = 1'b0; addr_i = 2'b10; data_i = 8'h33;
    repeat (4) @(negedge clk_i);
    xfer_ni = 1'b0;
    @(negedge clk_i); xfer_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_both("R10 held strobe no action");
    data_i = 8'h6D;
    @(negedge clk_i); wr_ni = 1'b1;
    @(negedge clk_i);
    m_in[1] = model_write(m_in[1], 1'b0, 8'h6D);
    op(0, 1, 0, 2'b00, 8'h00);
    chk_both("R10 release value used");

    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      logic wr, xf, cs;
      wr = ($urandom % 4) != 0;
      xf = ($urandom % 4) == 0;
      cs = ($urandom % 4) == 0;
      op(wr, xf, cs, 2'($urandom), 8'($urandom));
      chk_both("R7 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule